// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the combinational arithmetic and logic stage of a 32-bit integer datapath. It takes two operands and a 4-bit operation code and produces a result word together with three flags: zero, signed overflow and carry-out. Results and flags settle in the same cycle the operands arrive. The surrounding pipeline registers them and acts on them, for example by trapping on overflow or branching on zero.

The block supports four bitwise functions and one add/subtract path. The add/subtract path serves the add and subtract operations in trapping and non-trapping forms, and it also serves the signed and unsigned less-than comparisons. Equality is tested by subtracting and reading the zero flag. Immediates arrive already widened, because sign or zero extension is done upstream.

Top module: `ialu_core`

## Requirements
- R1: Code 0000 gives A AND B, 0001 gives A OR B, 1100 gives NOT (A OR B), and 1101 gives A XOR B. Each of these codes drives carry_o to 0.
- R2: Codes 0010 (add, trapping) and 0011 (add, non-trapping) give (A + B) mod 2^32. For both, carry_o is the carry out of bit 31.
- R3: Codes 0110 (subtract, trapping) and 0111 (subtract, non-trapping) give (A - B) mod 2^32. For both, carry_o is the carry out of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R4: Under code 0010, ovf_o is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R5: Under code 0110, ovf_o is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R6: ovf_o is 0 for every code other than 0010 and 0110. This includes the non-trapping add and subtract and both comparisons.
- R7: Code 1000 gives bit 0 = 1 when A < B as two's-complement numbers, and all other result bits are 0. The answer stays correct when A - B overflows. carry_o follows R3.
- R8: Code 1001 gives bit 0 = 1 when A < B as unsigned numbers, and all other result bits are 0. carry_o follows R3.
- R9: zero_o is 1 exactly when all 32 result bits are 0, under every code. Equal operands under code 0110 therefore give zero_o = 1.
- R10: Every code not listed above gives result 0, carry_o 0 and ovf_o 0, and therefore zero_o 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow, trapping add/subtract only |
| carry_o | output | 1 | Carry out of the adder for arithmetic and compare codes |

## Verification
The bench targets the operand pairs where a sloppy design gives itself away. The first is all-ones against one, which must give 1 for the signed comparison and 0 for the unsigned one; a design that swaps the two compares reverses both answers. The second is pairs whose difference overflows, such as the most negative value against one. A comparison that reads only the sign of the difference gets these wrong. The third is the same overflowing operands under the non-trapping codes and the compares, where a design that reports overflow for every arithmetic code raises a false trap. The bench also runs equal operands through subtract, to check that the zero flag tracks the result, and unused codes, which must give an all-zero result.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_ADDU = 4'b0011,
        OP_SUB  = 4'b0110,
        OP_SUBU = 4'b0111,
        OP_SLT  = 4'b1000,
        OP_SLTU = 4'b1001,
        OP_NOR  = 4'b1100,
        OP_XOR  = 4'b1101
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf_raw;
        logic lt_signed;
        logic lt_unsigned;
    } arith_flags_t;

    // Codes that run the adder with B inverted and carry-in forced high.
    function automatic logic needs_subtract(input logic [3:0] code);
        return (code == OP_SUB) || (code == OP_SUBU) ||
               (code == OP_SLT) || (code == OP_SLTU);
    endfunction

    // Codes whose signed overflow is reported to the pipeline.
    function automatic logic reports_overflow(input logic [3:0] code);
        return (code == OP_ADD) || (code == OP_SUB);
    endfunction

    // Codes whose result comes from the adder.
    function automatic logic uses_adder(input logic [3:0] code);
        return (code == OP_ADD)  || (code == OP_ADDU) ||
               (code == OP_SUB)  || (code == OP_SUBU) ||
               (code == OP_SLT)  || (code == OP_SLTU);
    endfunction

endpackage

// File: rtl/ialu_logic_unit.sv
module ialu_logic_unit
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    // One slice per bit; no carries cross between slices.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        always_comb begin
            unique case (op_i)
                OP_AND:  res_o[i] = a_i[i] & b_i[i];
                OP_OR:   res_o[i] = a_i[i] | b_i[i];
                OP_NOR:  res_o[i] = ~(a_i[i] | b_i[i]);
                OP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ialu_addsub.sv
module ialu_addsub
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output arith_flags_t     flags_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    assign b_eff = b_i ^ {WIDTH{sub_i}};
    assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    assign sum_o = wide[MSB:0];

    always_comb begin
        flags_o.carry       = wide[WIDTH];
        flags_o.ovf_raw     = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
        flags_o.lt_signed   = wide[MSB] ^ flags_o.ovf_raw;
        flags_o.lt_unsigned = ~wide[WIDTH];
    end

endmodule

// File: rtl/ialu_select.sv
module ialu_select
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] logic_res_i,
    input  logic [WIDTH-1:0] sum_i,
    input  arith_flags_t     flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             ovf_o,
    output logic             carry_o
);

    localparam logic [WIDTH-1:0] ZERO_W = '0;

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum_i;
            OP_SLT:  result_o = {ZERO_W[WIDTH-1:1], flags_i.lt_signed};
            OP_SLTU: result_o = {ZERO_W[WIDTH-1:1], flags_i.lt_unsigned};
            default: result_o = logic_res_i;
        endcase
        ovf_o   = reports_overflow(op_i) & flags_i.ovf_raw;
        carry_o = uses_adder(op_i) & flags_i.carry;
    end

endmodule

// File: rtl/ialu_core.sv
module ialu_core
    import ialu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             carry_o
);

    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] sum;
    arith_flags_t     flags;
    logic             do_sub;

    assign do_sub = needs_subtract(op_i);

    ialu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op_i),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (logic_res)
    );

    ialu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (do_sub),
        .sum_o   (sum),
        .flags_o (flags)
    );

    ialu_select #(.WIDTH(WIDTH)) u_select (
        .op_i        (op_i),
        .logic_res_i (logic_res),
        .sum_i       (sum),
        .flags_i     (flags),
        .result_o    (result_o),
        .ovf_o       (ovf_o),
        .carry_o     (carry_o)
    );

    assign zero_o = ~|result_o;

endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             ovf_o,
    input logic             carry_o
);

    localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        if (op_i == 4'b0000)
            assert_and_bitwise_R1: assert (result_o == (opa_i & opb_i) && !carry_o)
                else $error("R1 AND mismatch");
        if (op_i == 4'b0010 || op_i == 4'b0011)
            assert_add_sum_R2: assert (result_o == opa_i + opb_i)
                else $error("R2 add mismatch");
        if (op_i == 4'b0110 || op_i == 4'b0111)
            assert_sub_diff_R3: assert (result_o == opa_i - opb_i)
                else $error("R3 subtract mismatch");
        if (op_i != 4'b0010 && op_i != 4'b0110)
            assert_no_overflow_R6: assert (!ovf_o)
                else $error("R6 overflow on non-trapping code");
        if (op_i == 4'b1000)
            assert_slt_signed_R7: assert (result_o == (($signed(opa_i) < $signed(opb_i)) ? ONE_W : '0))
                else $error("R7 signed compare mismatch");
        if (op_i == 4'b1001)
            assert_sltu_unsigned_R8: assert (result_o == ((opa_i < opb_i) ? ONE_W : '0))
                else $error("R8 unsigned compare mismatch");
        if (op_i == 4'b0110 && opa_i == opb_i)
            assert_equal_zero_R9: assert (zero_o)
                else $error("R9 equal operands without zero");
    end

endmodule

bind ialu_core ialu_core_chk #(.WIDTH(WIDTH)) u_ialu_core_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o),
    .carry_o  (carry_o)
);

// File: tb/ialu_core_bench.sv
`timescale 1ns/1ps
module ialu_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [3:0]  op  = 4'b0000;
    logic [31:0] result;
    logic        zero, ovf, carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic [31:0] res;
        logic        z;
        logic        v;
        logic        c;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    ialu_core u_ialu_core (
        .opa_i(opa), .opb_i(opb), .op_i(op),
        .result_o(result), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
    );

    function automatic exp_t model(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        logic [32:0] s;
        logic [32:0] d;
        s = {1'b0, a} + {1'b0, b};
        d = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e = '0;
        case (code)
            4'b0000: e.res = a & b;
            4'b0001: e.res = a | b;
            4'b1100: e.res = ~(a | b);
            4'b1101: e.res = a ^ b;
            4'b0010, 4'b0011: begin
                e.res = s[31:0]; e.c = s[32];
                if (code == 4'b0010) e.v = (a[31] == b[31]) && (s[31] != a[31]);
            end
            4'b0110, 4'b0111: begin
                e.res = d[31:0]; e.c = d[32];
                if (code == 4'b0110) e.v = (a[31] != b[31]) && (d[31] != a[31]);
            end
            4'b1000: begin e.res = {31'd0, $signed(a) < $signed(b)}; e.c = d[32]; end
            4'b1001: begin e.res = {31'd0, a < b}; e.c = d[32]; end
            default: e.res = '0;
        endcase
        e.z = (e.res == 32'd0);
        return e;
    endfunction

    task automatic drive(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b, input string tag);
        @(posedge clk);
        op  = code;
        opa = a;
        opb = b;
        sb_q.push_back(model(code, a, b));
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t  e;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (result !== e.res || zero !== e.z || ovf !== e.v || carry !== e.c) begin
                fails++;
                $display("FAIL %s op=%b a=%h b=%h: actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
                         t, op, opa, opb, result, zero, ovf, carry, e.res, e.z, e.v, e.c);
            end
        end
    end

    function automatic logic [31:0] xs32(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        logic [31:0] seed;
        logic [3:0]  codes [10];
        codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0110,
                  4'b0111, 4'b1000, 4'b1001, 4'b1100, 4'b1101};

        // Reset state: inputs idle at zero, AND code
        drive(4'b0000, 32'h0, 32'h0, "R9 reset idle");
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // R1 bitwise functions
        drive(4'b0000, 32'h0000_3C00, 32'h0000_0D00, "R1 and");
        drive(4'b0001, 32'h0000_00C5, 32'h0000_000F, "R1 or");
        drive(4'b1100, 32'h0000_00C5, 32'h0000_000F, "R1 nor");
        drive(4'b1101, 32'hFFFF_0000, 32'hF0F0_F0F0, "R1 xor");
        drive(4'b1100, 32'h0,         32'h0,         "R1 nor of zeros");
        // R2 add and carry
        drive(4'b0010, 32'd7,         32'd3,         "R2 add small");
        drive(4'b0011, 32'hFFFF_FFFF, 32'd1,         "R2 addu carry wraps");
        // R4 add overflow, and R6 for the same operands under addu
        drive(4'b0010, 32'h7FFF_FFFF, 32'd1,         "R4 pos+pos overflow");
        drive(4'b0010, 32'h8000_0000, 32'h8000_0000, "R4 neg+neg overflow");
        drive(4'b0010, 32'hFFFF_FFFC, 32'hFFFF_FFFD, "R4 neg+neg no overflow");
        drive(4'b0011, 32'h7FFF_FFFF, 32'd1,         "R6 addu no overflow");
        // R3 subtract and carry
        drive(4'b0110, 32'd7,         32'd6,         "R3 sub");
        drive(4'b0111, 32'd3,         32'd5,         "R3 subu borrow");
        // R5 subtract overflow
        drive(4'b0110, 32'h8000_0000, 32'd1,         "R5 neg-pos overflow");
        drive(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 pos-neg overflow");
        drive(4'b0111, 32'h8000_0000, 32'd1,         "R6 subu no overflow");
        // R7 / R8 comparisons
        drive(4'b1000, 32'hFFFF_FFFF, 32'd1,         "R7 slt minus one vs one");
        drive(4'b1001, 32'hFFFF_FFFF, 32'd1,         "R8 sltu all ones vs one");
        drive(4'b1000, 32'h8000_0000, 32'd1,         "R7 slt overflowing diff");
        drive(4'b1000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R7 slt overflowing diff false");
        drive(4'b1001, 32'd1,         32'hFFFF_FFFF, "R8 sltu small vs large");
        drive(4'b1000, 32'd5,         32'd5,         "R7 slt equal");
        // R9 equality through subtract
        drive(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9 equal operands");
        // R10 unused codes
        drive(4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 unused 0100");
        drive(4'b1111, 32'h7FFF_FFFF, 32'd1,         "R10 unused 1111");
        drive(4'b0101, 32'h8000_0000, 32'h8000_0000, "R10 unused 0101");

        // Mixed patterns across all defined codes
        seed = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            seed = xs32(seed); a = seed;
            seed = xs32(seed); b = (i % 7 == 0) ? a : seed;
            drive(codes[i % 10], a, b, "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule